// File: doc/BRIEF.md
# ISA I/O Cycle Qualifier

This block sits between the ISA host bus and the local register targets of a peripheral. On every read or write strobe from the host it decides whether the cycle belongs to the device. Cycles that fall below the device's I/O window are refused. Cycles that happen while the bus carries a DMA transfer are also refused. Each accepted cycle is handed to a local target through a select/acknowledge handshake, and the host is held off through the open-drain ready line until the target answers.

DMA activity is taken from the AEN pin. In addition, a DMA cycle can be inferred when the host drives the whole address bus to zero, because some chipsets mark DMA that way. A bit in an 8-bit configuration register turns this zero-address inference off. That register survives the operating reset and is cleared only at power-up.

The sampling clock runs faster than the bus strobes. The address and direction are captured on the clock that first sees a strobe, so a claim cannot change once it is made.

Top module: `isa_io_qualifier`

## Requirements
- R1: The configuration register is 8 bits wide at configuration offset 1Eh and holds 00h at power-up. It is written when `cfgSel` and `cfgWr` are both high on a clock edge with `cfgAddr` = 1Eh. `cfgRdata` shows the register while `cfgSel` is high and `cfgAddr` = 1Eh, and shows 00h otherwise.
- R2: While `rst` is high, `tgtSel` and `iochrdyOe` are low after each clock edge. `rst` never alters the configuration register.
- R3: While bit 1 of the configuration register is 0, `dmaFlag` is high when `aenPin` is high or `isaAddr` equals 0000h. No cycle is claimed when `dmaFlag` is high on the clock that samples the strobe's leading edge.
- R4: While bit 1 of the configuration register is 1, `dmaFlag` follows `aenPin` alone, and an all-zero address does not raise it.
- R5: A cycle is claimed only when `isaAddr` is 0100h or higher. Lower addresses never raise `tgtSel`.
- R6: On a claimed cycle, `iochrdyOe` (1 = pull the ready line low) and `tgtSel` go high after the clock edge that first samples a strobe low. No other event raises them.
- R7: When `tgtAck` is high at a clock edge during a claimed cycle, `tgtSel` and `iochrdyOe` are low after that edge. An acknowledge sampled on the k-th edge after the claim gives k cycles of select.
- R8: If no acknowledge arrives, a claimed cycle ends after 16 cycles of select (parameter `TIMEOUT_CLKS`).
- R9: `tgtAddr` and `tgtWrite` (1 = write strobe `iowN`, 0 = read strobe `iorN`) are captured at the leading edge and stay stable while `tgtSel` is high, even if the bus address changes.
- R10: A strobe held low after its cycle ends is not claimed a second time. A strobe edge where `iorN` and `iowN` are both low is never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Active-high operating reset |
| isaAddr | input | 16 | ISA address bus |
| iorN | input | 1 | I/O read strobe, active low |
| iowN | input | 1 | I/O write strobe, active low |
| aenPin | input | 1 | AEN pin, high during DMA |
| cfgSel | input | 1 | Configuration port select |
| cfgWr | input | 1 | Configuration write enable |
| cfgAddr | input | 8 | Configuration offset |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data |
| dmaFlag | output | 1 | Qualified DMA-active indication |
| iochrdyOe | output | 1 | 1 = pull ready line low |
| tgtSel | output | 1 | Local target select |
| tgtWrite | output | 1 | Captured direction, 1 = write |
| tgtAddr | output | 16 | Captured address |
| tgtAck | input | 1 | Local target acknowledge |

## Verification
The bench runs cycles on both sides of the window boundary, at 00FFh and at 0100h. A design that compares the wrong way claims 00FFh or refuses 0100h. It runs zero-address cycles in both AEN modes: a design that ignores the control bit raises `dmaFlag` where it must stay low, or the reverse. It moves the bus address in the middle of a claimed cycle to catch a design that decodes live instead of from its capture. It holds a strobe low long past a timeout to catch a design that claims the same strobe again. It also checks an acknowledge after a few clocks against a 16-clock timeout, which exposes off-by-one release timing. Finally, it asserts reset after the configuration register has been written and expects the register to keep its value.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } iqState_t;

  typedef struct packed {
    logic capture;
    logic cntClr;
    logic cntInc;
  } iqStrobes_t;
endpackage

// File: rtl/iq_datapath.sv
module iq_datapath
  import iq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned CFG_OFFSET   = 'h1E,
  parameter int unsigned AEN_BIT      = 1,
  parameter int unsigned LOW_LIMIT    = 'h100,
  parameter int unsigned TIMEOUT_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] isaAddr,
  input  logic              iowN,
  input  logic              aenPin,
  input  logic              cfgSel,
  input  logic              cfgWr,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWdata,
  input  iqStrobes_t        strb,
  output logic [7:0]        cfgRdata,
  output logic              dmaFlag,
  output logic              claimOk,
  output logic              timeoutHit,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic              tgtWrite
);
  localparam int unsigned CNT_W = (TIMEOUT_CLKS > 2) ? $clog2(TIMEOUT_CLKS) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TIMEOUT_CLKS - 1);
  localparam logic [ADDR_W-1:0] ADDR_MIN = ADDR_W'(LOW_LIMIT);
  localparam logic [7:0]        CFG_ADR  = 8'(CFG_OFFSET);

  // Configuration register: cleared at power-up only, untouched by rst.
  logic [7:0] cfgReg = 8'h00;
  logic       cfgHit;

  assign cfgHit = cfgSel && (cfgAddr == CFG_ADR);

  always_ff @(posedge clk) begin
    if (cfgHit && cfgWr) cfgReg <= cfgWdata;
  end

  assign cfgRdata = cfgHit ? cfgReg : 8'h00;

  // DMA qualification and window decode on the live bus
  logic addrZero;
  assign addrZero = (isaAddr == '0);
  assign dmaFlag  = aenPin || (!cfgReg[AEN_BIT] && addrZero);
  assign claimOk  = !dmaFlag && (isaAddr >= ADDR_MIN);

  // Capture of address and direction at the strobe's leading edge
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      tgtAddr  <= isaAddr;
      tgtWrite <= !iowN;
    end
  end

  // Cycle-length counter for the acknowledge timeout
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (rst)              waitCnt <= '0;
    else if (strb.cntClr) waitCnt <= '0;
    else if (strb.cntInc) waitCnt <= waitCnt + 1'b1;
  end

  assign timeoutHit = (waitCnt == CNT_LAST);
endmodule

// File: rtl/iq_control.sv
module iq_control
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       iorN,
  input  logic       iowN,
  input  logic       claimOk,
  input  logic       timeoutHit,
  input  logic       tgtAck,
  output iqStrobes_t strb,
  output logic       tgtSel,
  output logic       iochrdyOe
);
  iqState_t state, stateNxt;
  logic     strobePrev;
  logic     strobeAny;
  logic     strobeOne;
  logic     leadEdge;

  assign strobeAny = !iorN || !iowN;
  assign strobeOne = iorN ^ iowN;
  assign leadEdge  = strobeAny && !strobePrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      strobePrev <= 1'b0;
    end else begin
      state      <= stateNxt;
      strobePrev <= strobeAny;
    end
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (leadEdge && strobeOne && claimOk) stateNxt = ST_BUSY;
      ST_BUSY: if (tgtAck || timeoutHit) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.capture = (state == ST_IDLE) && leadEdge;
    strb.cntClr  = strb.capture;
    strb.cntInc  = (state == ST_BUSY) && !tgtAck && !timeoutHit;
  end

  assign tgtSel    = (state == ST_BUSY);
  assign iochrdyOe = (state == ST_BUSY);
endmodule

// File: rtl/isa_io_qualifier.sv
module isa_io_qualifier
  import iq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned CFG_OFFSET   = 'h1E,
  parameter int unsigned AEN_BIT      = 1,
  parameter int unsigned LOW_LIMIT    = 'h100,
  parameter int unsigned TIMEOUT_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] isaAddr,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              aenPin,
  input  logic              cfgSel,
  input  logic              cfgWr,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output logic              dmaFlag,
  output logic              iochrdyOe,
  output logic              tgtSel,
  output logic              tgtWrite,
  output logic [ADDR_W-1:0] tgtAddr,
  input  logic              tgtAck
);
  iqStrobes_t strb;
  logic       claimOk;
  logic       timeoutHit;

  iq_datapath #(
    .ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET), .AEN_BIT(AEN_BIT),
    .LOW_LIMIT(LOW_LIMIT), .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) u_dp (
    .clk(clk), .rst(rst), .isaAddr(isaAddr), .iowN(iowN), .aenPin(aenPin),
    .cfgSel(cfgSel), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .strb(strb), .cfgRdata(cfgRdata), .dmaFlag(dmaFlag), .claimOk(claimOk),
    .timeoutHit(timeoutHit), .tgtAddr(tgtAddr), .tgtWrite(tgtWrite)
  );

  iq_control u_ctl (
    .clk(clk), .rst(rst), .iorN(iorN), .iowN(iowN), .claimOk(claimOk),
    .timeoutHit(timeoutHit), .tgtAck(tgtAck), .strb(strb),
    .tgtSel(tgtSel), .iochrdyOe(iochrdyOe)
  );
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned LOW_LIMIT    = 'h100,
  parameter int unsigned TIMEOUT_CLKS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              iorN,
  input logic              iowN,
  input logic              dmaFlag,
  input logic              iochrdyOe,
  input logic              tgtSel,
  input logic [ADDR_W-1:0] tgtAddr,
  input logic              tgtAck
);
  int unsigned selRun;

  always_ff @(posedge clk) begin
    if (rst)         selRun <= 0;
    else if (tgtSel) selRun <= selRun + 1;
    else             selRun <= 0;
  end

  // R5: a claimed cycle never targets the low window
  a_r5_low_addr_rejected: assert property (@(posedge clk) disable iff (rst)
    $rose(tgtSel) |-> (tgtAddr >= ADDR_W'(LOW_LIMIT)));

  // R3: no claim when DMA was flagged at the sampling edge
  a_r3_no_claim_in_dma: assert property (@(posedge clk) disable iff (rst)
    $rose(tgtSel) |-> $past(!dmaFlag));

  // R6: ready is pulled only after a strobe was seen low
  a_r6_ready_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(iochrdyOe) |-> $past(!iorN || !iowN));

  // R7: acknowledge ends the cycle at the next edge
  a_r7_ack_release: assert property (@(posedge clk) disable iff (rst)
    (tgtSel && tgtAck) |=> !tgtSel);

  // R9: captured address holds through the cycle
  a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
    (tgtSel && $past(tgtSel)) |-> $stable(tgtAddr));

  // R8: select never lasts past the timeout
  a_r8_timeout_bound: assert property (@(posedge clk) disable iff (rst)
    selRun <= TIMEOUT_CLKS);
endmodule

bind isa_io_qualifier iq_checker #(
  .ADDR_W(ADDR_W), .LOW_LIMIT(LOW_LIMIT), .TIMEOUT_CLKS(TIMEOUT_CLKS)
) u_chk (
  .clk(clk), .rst(rst), .iorN(iorN), .iowN(iowN), .dmaFlag(dmaFlag),
  .iochrdyOe(iochrdyOe), .tgtSel(tgtSel), .tgtAddr(tgtAddr), .tgtAck(tgtAck)
);

// File: tb/sim_isa_io_qualifier.sv
module sim_isa_io_qualifier;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] isaAddr = 16'h0000;
  logic        iorN = 1'b1, iowN = 1'b1, aenPin = 1'b0;
  logic        cfgSel = 1'b1, cfgWr = 1'b0;
  logic [7:0]  cfgAddr = 8'h1E, cfgWdata = 8'h00;
  logic [7:0]  cfgRdata;
  logic        dmaFlag, iochrdyOe, tgtSel, tgtWrite, tgtAck = 1'b0;
  logic [15:0] tgtAddr;

  always #2 clk = ~clk;

  isa_io_qualifier u0 (
    .clk(clk), .rst(rst), .isaAddr(isaAddr), .iorN(iorN), .iowN(iowN),
    .aenPin(aenPin), .cfgSel(cfgSel), .cfgWr(cfgWr), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .dmaFlag(dmaFlag),
    .iochrdyOe(iochrdyOe), .tgtSel(tgtSel), .tgtWrite(tgtWrite),
    .tgtAddr(tgtAddr), .tgtAck(tgtAck)
  );

  int checks = 0, errors = 0, selCount = 0, cycles = 0;
  bit done = 0;

  // Behavioural reference
  bit        mBusy = 0, mPrev = 0, mWr = 0;
  int        mCnt = 0;
  logic [15:0] mAddr = 0;
  logic [7:0]  mCfg = 8'h00;

  always @(posedge clk) begin
    bit anyS, oneS, dmaNow;
    anyS = !iorN || !iowN;
    oneS = (iorN != iowN);
    if (cfgSel && cfgWr && cfgAddr == 8'h1E) mCfg = cfgWdata;
    if (rst) begin
      mBusy = 0; mPrev = 0; mCnt = 0;
    end else begin
      if (mBusy) begin
        if (tgtAck || mCnt == TMO - 1) mBusy = 0;
        else mCnt++;
      end else if (anyS && !mPrev) begin
        mAddr = isaAddr;
        mWr = !iowN;
        dmaNow = aenPin || (!mCfg[1] && isaAddr == 16'h0000);
        if (oneS && !dmaNow && isaAddr >= 16'h0100) begin
          mBusy = 1; mCnt = 0;
        end
      end
      mPrev = anyS;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit expDma;
    logic [7:0] expRd;
    @(posedge clk);
    #1;
    expDma = aenPin || (!mCfg[1] && isaAddr == 16'h0000);
    expRd  = (cfgSel && cfgAddr == 8'h1E) ? mCfg : 8'h00;
    chk(iochrdyOe === mBusy, "R6 ready pull", 32'(iochrdyOe), 32'(mBusy));
    chk(tgtSel === mBusy, "R6 select", 32'(tgtSel), 32'(mBusy));
    if (mBusy) begin
      chk(tgtAddr === mAddr, "R9 captured address", 32'(tgtAddr), 32'(mAddr));
      chk(tgtWrite === mWr, "R9 captured direction", 32'(tgtWrite), 32'(mWr));
    end
    chk(dmaFlag === expDma, "R3 dma flag", 32'(dmaFlag), 32'(expDma));
    chk(cfgRdata === expRd, "R1 config read", 32'(cfgRdata), 32'(expRd));
    if (tgtSel === 1'b1) selCount++;
  endtask

  task automatic runCycle(logic [15:0] a, bit wr, bit aen, int ackAt, int hold, bit moveAddr);
    isaAddr = a; aenPin = aen; selCount = 0;
    if (wr) iowN = 1'b0; else iorN = 1'b0;
    for (int i = 0; i < hold; i++) begin
      tgtAck = (ackAt > 0 && i == ackAt);
      if (moveAddr && i == 2) isaAddr = isaAddr ^ 16'h0A5A;
      step();
    end
    tgtAck = 1'b0; iorN = 1'b1; iowN = 1'b1; aenPin = 1'b0;
    step(); step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) step();
    chk(cfgRdata == 8'h00, "R1 power-up value", 32'(cfgRdata), 0);
    chk(!tgtSel && !iochrdyOe, "R2 reset outputs", 32'(tgtSel), 0);
    rst = 1'b0;
    step();

    runCycle(16'h03F8, 0, 0, 3, 8, 0);
    chk(selCount == 3, "R7 ack release read", selCount, 3);
    runCycle(16'h02F8, 1, 0, 5, 10, 1);
    chk(selCount == 5, "R7 ack release write, R9 moved address", selCount, 5);

    runCycle(16'h00FF, 0, 0, 2, 6, 0);
    chk(selCount == 0, "R5 below window", selCount, 0);
    runCycle(16'h0100, 1, 0, 2, 6, 0);
    chk(selCount == 2, "R5 window start", selCount, 2);

    runCycle(16'h0300, 0, 1, 2, 6, 0);
    chk(selCount == 0, "R3 aen pin blocks claim", selCount, 0);
    isaAddr = 16'h0000; step();
    chk(dmaFlag == 1'b1, "R3 zero address flag", 32'(dmaFlag), 1);

    cfgWdata = 8'h02; cfgWr = 1'b1; step();
    cfgWr = 1'b0; step();
    chk(cfgRdata == 8'h02, "R1 write readback", 32'(cfgRdata), 32'h02);
    cfgAddr = 8'h1D; step();
    chk(cfgRdata == 8'h00, "R1 other offset", 32'(cfgRdata), 0);
    cfgAddr = 8'h1E; step();
    isaAddr = 16'h0000; aenPin = 1'b0; step();
    chk(dmaFlag == 1'b0, "R4 zero address ignored", 32'(dmaFlag), 0);
    aenPin = 1'b1; step();
    chk(dmaFlag == 1'b1, "R4 aen pin alone", 32'(dmaFlag), 1);
    aenPin = 1'b0; step();

    runCycle(16'h0400, 0, 0, 0, 24, 0);
    chk(selCount == TMO, "R8 timeout length", selCount, TMO);
    runCycle(16'h0500, 1, 0, 0, 44, 0);
    chk(selCount == TMO, "R10 held strobe not reclaimed", selCount, TMO);

    isaAddr = 16'h0300; iorN = 1'b0; iowN = 1'b0; selCount = 0;
    for (int i = 0; i < 6; i++) step();
    iorN = 1'b1; iowN = 1'b1; step(); step();
    chk(selCount == 0, "R10 both strobes refused", selCount, 0);

    isaAddr = 16'h0600; iorN = 1'b0; step(); step(); step();
    rst = 1'b1; iorN = 1'b1; step(); step();
    chk(!tgtSel && !iochrdyOe, "R2 reset ends cycle", 32'(tgtSel), 0);
    rst = 1'b0; step();
    chk(cfgRdata == 8'h02, "R2 config kept over reset", 32'(cfgRdata), 32'h02);

    runCycle(16'h0000, 0, 0, 2, 6, 0);
    chk(selCount == 0, "R5 zero address in pin-only mode", selCount, 0);
    finishRun();
  end
endmodule